// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked, synchronous pulse stretcher with an overriding clear. Three asynchronous control lines come in: a trigger that acts on its falling edge, a trigger that acts on its rising edge, and an active-low clear. All three pass through a synchronizer. Edges are judged on the synchronized values. A qualifying edge loads a down-counter with the pulse width given on `width_i`, measured in clock cycles. The output stays high while that counter is nonzero.

Each trigger qualifies against the other lines. A falling edge on `fall_trig_i` counts only while `rise_trig_i` is high and the clear is inactive. A rising edge on `rise_trig_i` counts only while `fall_trig_i` is low and the clear is inactive. A qualifying edge that arrives during a pulse restarts the full width.

Driving the clear low ends any pulse and beats a trigger seen in the same cycle. The parameter `RELEASE_FIRES` picks one of two variants. When it is 1, the clear going inactive also fires, provided `fall_trig_i` is low and `rise_trig_i` is high. When it is 0, releasing the clear never fires.

Top module: `oneshot_retrig`

## Requirements
- R1: While `rst` is high, and after it falls, `pulse_o` is 0 and `pulse_n_o` is 1. Input levels that already meet a trigger condition when `rst` is released start no pulse. Only a later edge does.
- R2: A 1-to-0 change on `fall_trig_i` starts a pulse while `rise_trig_i`=1 and `clear_n_i`=1. When the inputs change before clock edge n, `pulse_o` rises just after edge n+2.
- R3: A 0-to-1 change on `rise_trig_i` starts a pulse while `fall_trig_i`=0 and `clear_n_i`=1, with the same latency as R2.
- R4: No pulse starts, and the outputs stay idle, in any of these cases:
  - `fall_trig_i` falls while `rise_trig_i`=0;
  - `rise_trig_i` rises while `fall_trig_i`=1;
  - either edge occurs while `clear_n_i`=0;
  - the level changes are not the qualifying ones (`fall_trig_i` rising, `rise_trig_i` falling).
- R5: An accepted trigger holds `pulse_o` high for exactly `width_i` clock cycles, with `width_i` sampled in the cycle the trigger is accepted. A width of 0 produces no pulse.
- R6: A qualifying edge during an active pulse reloads the width. `pulse_o` then stays high until `width_i` cycles after the latest accepted trigger.
- R7: With `clear_n_i`=0, `pulse_o` goes to 0 after the same synchronizer latency as R2 and stays 0 while the clear is held. The clear wins over a trigger edge seen in the same cycle.
- R8: With `RELEASE_FIRES`=1, a 0-to-1 change on `clear_n_i` while `fall_trig_i`=0 and `rise_trig_i`=1 starts a pulse, with the latency of R2. With `RELEASE_FIRES`=0 the same stimulus leaves `pulse_o` at 0.
- R9: `pulse_n_o` is the complement of `pulse_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| fall_trig_i | input | 1 | Asynchronous trigger, acts on its falling edge |
| rise_trig_i | input | 1 | Asynchronous trigger, acts on its rising edge |
| clear_n_i | input | 1 | Asynchronous active-low clear; its release may fire when `RELEASE_FIRES`=1 |
| width_i | input | CNT_W | Pulse width in clock cycles |
| pulse_o | output | 1 | Registered pulse output |
| pulse_n_o | output | 1 | Registered complement of `pulse_o` |

## Verification
The bench goes after the moment `rst` is released with the trigger levels already set, where a design that lost its edge history would fire a spurious pulse. It also goes after a retrigger partway through a pulse, where a design that did not reload would end the pulse early. Width 0 and width 1 are both driven, which shows off-by-one errors in the counter as a missing cycle or a stuck output. A clear applied in the same cycle as a trigger edge, and the clear-release stimulus run on both variants side by side, catch a wrong priority or a wrongly wired variant as an unexpected pulse or a missing one.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Synchronized view of the three control lines
  typedef struct packed {
    logic fall_trig;
    logic rise_trig;
    logic clear_n;
  } trig_lines_t;

  localparam int LINE_COUNT = $bits(trig_lines_t);

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/oneshot_qualify.sv
module oneshot_qualify
  import oneshot_pkg::*;
#(
  parameter int STAGES        = 2,
  parameter bit RELEASE_FIRES = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  trig_lines_t cur,
  output logic        fire,
  output logic        clear_act
);

  // The history is valid only once the sync chain and the prev register hold real data
  localparam int WARM_W = STAGES + 1;

  trig_lines_t       prev;
  logic [WARM_W-1:0] warm;
  logic              armed;
  logic              fall_hit, rise_hit, release_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      warm <= '0;
    end else begin
      prev <= cur;
      warm <= {warm[WARM_W-2:0], 1'b1};
    end
  end

  assign armed     = warm[WARM_W-1];
  assign clear_act = ~cur.clear_n;

  assign fall_hit = prev.fall_trig & ~cur.fall_trig & cur.rise_trig;
  assign rise_hit = ~prev.rise_trig & cur.rise_trig & ~cur.fall_trig;

  if (RELEASE_FIRES) begin : g_release
    assign release_hit = ~prev.clear_n & ~cur.fall_trig & cur.rise_trig;
  end else begin : g_no_release
    assign release_hit = 1'b0;
  end

  assign fire = armed & cur.clear_n & (fall_hit | rise_hit | release_hit);

  AST_NO_FIRE_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !warm[0] |-> !fire); // R1

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             fire,
  input  logic [CNT_W-1:0] width,
  output logic             pulse,
  output logic             pulse_n
);

  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    if (clear)          cnt_nxt = '0;
    else if (fire)      cnt_nxt = width;
    else if (cnt != '0) cnt_nxt = cnt - 1'b1;
    else                cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse   <= 1'b0;
      pulse_n <= 1'b1;
    end else begin
      cnt     <= cnt_nxt;
      pulse   <= (cnt_nxt != '0);
      pulse_n <= (cnt_nxt == '0);
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0) && !pulse); // R7
  AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (fire && !clear) |=> cnt == $past(width)); // R6
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!fire && !clear && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R5

endmodule

// File: rtl/oneshot_retrig.sv
module oneshot_retrig
  import oneshot_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int SYNC_STAGES   = 2,
  parameter bit RELEASE_FIRES = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_trig_i,
  input  logic             rise_trig_i,
  input  logic             clear_n_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  trig_lines_t raw, synced;
  logic        fire, clear_act;

  assign raw = '{fall_trig: fall_trig_i, rise_trig: rise_trig_i, clear_n: clear_n_i};

  oneshot_sync #(
    .WIDTH  (LINE_COUNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  oneshot_qualify #(
    .STAGES        (SYNC_STAGES),
    .RELEASE_FIRES (RELEASE_FIRES)
  ) u_qualify (
    .clk       (clk),
    .rst       (rst),
    .cur       (synced),
    .fire      (fire),
    .clear_act (clear_act)
  );

  oneshot_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear_act),
    .fire    (fire),
    .width   (width_i),
    .pulse   (pulse_o),
    .pulse_n (pulse_n_o)
  );

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    pulse_o != pulse_n_o); // R9
  AST_RISE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(fire)); // R2

endmodule

// File: tb/oneshot_retrig_bench.sv
module oneshot_retrig_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int WATCHDOG   = 5000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fa  = 1'b1;
  logic             rb  = 1'b0;
  logic             cn  = 1'b1;
  logic [CNT_W-1:0] w   = 16'd5;
  logic             q1, qn1, q0, qn0;

  int    n_vec  = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done   = 1'b0;

  // Expected outputs per cycle, [0]=release-fires variant, [1]=no-release variant
  bit exp_q1 [$];
  bit exp_q0 [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_retrig #(.CNT_W(CNT_W), .RELEASE_FIRES(1'b1)) u_oneshot_retrig (
    .clk(clk), .rst(rst), .fall_trig_i(fa), .rise_trig_i(rb), .clear_n_i(cn),
    .width_i(w), .pulse_o(q1), .pulse_n_o(qn1));

  oneshot_retrig #(.CNT_W(CNT_W), .RELEASE_FIRES(1'b0)) u_oneshot_retrig_nr (
    .clk(clk), .rst(rst), .fall_trig_i(fa), .rise_trig_i(rb), .clear_n_i(cn),
    .width_i(w), .pulse_o(q0), .pulse_n_o(qn0));

  // Reference model from the requirements: two-cycle input latency, edge
  // history armed one cycle after it holds real data, clear beats trigger.
  bit [2:0] m_s1, m_s2, m_p;   // {fall, rise, clear_n}
  int       m_warm;
  int       m_cnt [2];

  always @(posedge clk) begin
    bit fall_e, rise_e, rel_e, armed;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_p = '0; m_warm = 0;
      m_cnt[0] = 0; m_cnt[1] = 0;
    end else begin
      armed  = (m_warm >= 3);
      fall_e = m_p[2] && !m_s2[2] && m_s2[1];
      rise_e = !m_p[1] && m_s2[1] && !m_s2[2];
      rel_e  = !m_p[0] && !m_s2[2] && m_s2[1];
      for (int v = 0; v < 2; v++) begin
        if (!m_s2[0])
          m_cnt[v] = 0;
        else if (armed && (fall_e || rise_e || (v == 0 && rel_e)))
          m_cnt[v] = int'(w);
        else if (m_cnt[v] != 0)
          m_cnt[v] = m_cnt[v] - 1;
      end
      m_p  = m_s2;
      m_s2 = m_s1;
      m_s1 = {fa, rb, cn};
      if (m_warm < 3) m_warm++;
    end
    exp_q1.push_back(m_cnt[0] != 0);
    exp_q0.push_back(m_cnt[1] != 0);
  end

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    bit e1, e0;
    if (exp_q1.size() > 0 && !done) begin
      e1 = exp_q1.pop_front();
      e0 = exp_q0.pop_front();
      n_vec++;
      if (q1 !== e1) begin
        n_fail++;
        $display("FAIL %s release-fires variant pulse_o actual=%0b expected=%0b t=%0t", cur_req, q1, e1, $time);
      end
      if (q0 !== e0) begin
        n_fail++;
        $display("FAIL %s no-release variant pulse_o actual=%0b expected=%0b t=%0t", cur_req, q0, e0, $time);
      end
      if (qn1 !== ~q1 || qn0 !== ~q0) begin
        n_fail++;
        $display("FAIL R9 complement actual=%0b%0b/%0b%0b expected=%0b%0b/%0b%0b",
                 q1, qn1, q0, qn0, q1, ~q1, q0, ~q0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input bit a, input bit b, input bit c, input string req);
    @(negedge clk);
    cur_req = req;
    fa = a; rb = b; cn = c;
  endtask

  initial begin
    // R1: trigger-ready levels held across reset release
    fa = 1'b0; rb = 1'b1; cn = 1'b1; cur_req = "R1";
    idle(4);
    rst = 1'b0;
    idle(10);
    drive(1, 0, 1, "R4");            // non-qualifying level changes
    idle(8);
    // R2: fall trigger with rise line high
    drive(1, 1, 1, "R4");            // rise edge while fall line high: ignored
    idle(8);
    drive(0, 1, 1, "R2");
    idle(10);
    // R3: rise trigger with fall line low
    drive(0, 0, 1, "R3");
    idle(6);
    drive(0, 1, 1, "R3");
    idle(10);
    // R4: fall edge while rise line low, edges while cleared
    drive(1, 0, 1, "R4"); idle(4);
    drive(0, 0, 1, "R4"); idle(6);
    drive(0, 0, 0, "R4"); idle(4);
    drive(0, 1, 0, "R4"); idle(6);
    drive(1, 1, 0, "R4"); idle(4);
    drive(1, 1, 1, "R4"); idle(6);
    // R6: retrigger in mid-pulse
    w = 16'd8;
    drive(0, 1, 1, "R6"); idle(4);
    drive(0, 0, 1, "R6"); idle(1);
    drive(0, 1, 1, "R6"); idle(14);
    // R5: width 1 and width 0
    w = 16'd1;
    drive(0, 0, 1, "R5"); idle(4);
    drive(0, 1, 1, "R5"); idle(6);
    w = 16'd0;
    drive(0, 0, 1, "R5"); idle(4);
    drive(0, 1, 1, "R5"); idle(6);
    // R7: clear during a pulse, then clear together with a trigger edge
    w = 16'd20;
    drive(0, 0, 1, "R7"); idle(4);
    drive(0, 1, 1, "R7"); idle(6);
    drive(0, 1, 0, "R7"); idle(6);
    drive(1, 1, 0, "R7"); idle(2);
    drive(1, 1, 1, "R7"); idle(4);
    drive(0, 1, 0, "R7"); idle(8);   // fall edge and clear applied together
    // R8: clear release with fall low and rise high
    w = 16'd6;
    drive(0, 1, 1, "R8"); idle(12);
    drive(0, 1, 0, "R8"); idle(5);
    drive(0, 1, 1, "R8"); idle(12);
    // R8: release with wrong levels fires in neither variant
    drive(1, 1, 0, "R8"); idle(5);
    drive(1, 1, 1, "R8"); idle(12);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    done = 1'b1;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule